// File: doc/BRIEF.md
# Branch target identification checker

This block sits in the decode stage of a 64-bit processor core and enforces landing-pad discipline on indirect branches. Each instruction that decode presents is looked at in the light of a two-bit branch-type state. That state holds the kind of branch that brought control to the instruction. The block recognises the landing-pad hint encoding and decodes which branch kinds the hint admits. When the fetch address lies in a guarded region and the state is nonzero, the block raises a branch target exception for any instruction that is not a compatible landing pad.

Once an instruction has been checked, the block computes the branch-type state for the next instruction:
- A faulting instruction leaves the state as it was.
- A landing pad, or any other hint from the same hint space, clears the state to 00.
- Every other instruction loads the branch type that the branch unit reports for it.

All results are registered. They appear in the cycle after the instruction was presented.

Top module: `bti_guard_checker`

## Requirements
- R1: A word is a landing pad when bits [31:12] are 11010101000000110010, bits [11:8] are 0100, bits [4:0] are 11111, and bits [7:5] are 000, 010, 100 or 110.
  - For such a word, `pad_seen` is 1 in the cycle after the valid word.
  - `pad_form` then gives the admitted branch kinds: 00 none, 01 C, 10 J, 11 JC. This is bits [7:6] of the word.
  - For any other word, `pad_seen` and `pad_form` are 0. The base encoding 0xD503241F is a landing pad with form 00.
- R2: A valid instruction whose `in_guarded` is 0 never raises `target_fault`, whatever the word and the state.
- R3: A valid instruction in a guarded region, while `btype_state` is 00, never raises `target_fault`.
- R4: A landing pad in a guarded region raises no fault when its form admits the nonzero current state. State 01 is admitted by C, J and JC. State 10 is admitted by C and JC. State 11 is admitted by J and JC. Form none admits no nonzero state.
- R5: In a guarded region with a nonzero state, `target_fault` is 1 in the cycle after any valid word that is not an admitting landing pad. It is 0 again in the following cycle unless another such word is presented.
- R6: After a valid non-faulting word from the hint space, `btype_state` becomes 00 whatever `in_btype` is. The hint space is the landing pads plus the same pattern with bits [7:5] odd.
- R7: After a valid non-faulting word outside the hint space, `btype_state` becomes `in_btype`.
- R8: After a faulting word, `btype_state` keeps its previous value.
- R9: While `in_valid` is 0, `btype_state` holds its value, and `target_fault` and `pad_seen` are 0 in the next cycle.
- R10: During and after synchronous reset, `btype_state` is 00, and `target_fault`, `pad_seen` and `pad_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented this cycle |
| in_word | input | 32 | Instruction word |
| in_guarded | input | 1 | Fetch address of the instruction lies in a guarded region |
| in_btype | input | 2 | Branch type the branch unit reports for this instruction |
| target_fault | output | 1 | Branch target exception pulse for the previous valid instruction |
| pad_seen | output | 1 | Previous valid instruction was a landing pad |
| pad_form | output | 2 | Admitted branch kinds of that landing pad |
| btype_state | output | 2 | Branch-type state checked against the next instruction |

## Verification
Two functions can fall in the same cycle: the fault decision and the state update. When both apply, the rule that a fault freezes the state must win over loading `in_btype` or clearing to 00.

The bench provokes the collision in two ways:
- It presents non-pad words and mismatching pads in guarded regions while driving a nonzero `in_btype` that differs from the held state.
- It presents odd-op2 hints, which would clear the state if they did not fault.

The checks then judge `target_fault` together with `btype_state` in the following cycle. They use a bench-side model of the compatibility table.

// File: rtl/bti_pkg.sv
package bti_pkg;

    localparam int WORD_W   = 32;
    localparam int BTYPE_W  = 2;
    localparam int FORM_W   = 2;

    localparam logic [19:0] HINT_HI   = 20'b11010101000000110010;
    localparam logic [3:0]  HINT_CRM  = 4'b0100;
    localparam logic [4:0]  HINT_RT   = 5'b11111;

    typedef enum logic [FORM_W-1:0] {
        FORM_NONE = 2'b00,
        FORM_C    = 2'b01,
        FORM_J    = 2'b10,
        FORM_JC   = 2'b11
    } pad_form_e;

    typedef logic [BTYPE_W-1:0] btype_t;

    typedef struct packed {
        logic      in_hint_space;
        logic      is_pad;
        pad_form_e form;
    } decode_t;

    function automatic decode_t decode_word(input logic [WORD_W-1:0] w);
        decode_t d;
        d.in_hint_space = (w[31:12] == HINT_HI) && (w[11:8] == HINT_CRM)
                       && (w[4:0] == HINT_RT);
        d.is_pad = d.in_hint_space && !w[5];
        d.form   = d.is_pad ? pad_form_e'(w[7:6]) : FORM_NONE;
        return d;
    endfunction

    function automatic logic form_admits(input pad_form_e f, input btype_t bt);
        logic ok;
        case (bt)
            2'b00:   ok = 1'b1;
            2'b01:   ok = (f != FORM_NONE);
            2'b10:   ok = f[0];
            default: ok = f[1];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bti_word_decoder.sv
module bti_word_decoder
    import bti_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output decode_t           dec
);
    always_comb begin
        dec = decode_word(word);
    end
endmodule

// File: rtl/bti_fault_judge.sv
module bti_fault_judge
    import bti_pkg::*;
(
    input  logic    valid,
    input  logic    guarded,
    input  btype_t  cur_btype,
    input  decode_t dec,
    output logic    fault
);
    logic admitted;
    logic armed;

    always_comb begin
        admitted = dec.is_pad && form_admits(dec.form, cur_btype);
        armed    = valid && guarded && (cur_btype != '0);
        fault    = armed && !admitted;
    end
endmodule

// File: rtl/bti_btype_reg.sv
module bti_btype_reg
    import bti_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid,
    input  logic   fault,
    input  logic   hint,
    input  btype_t load_btype,
    output btype_t state_q
);
    btype_t state_d;

    always_comb begin
        state_d = state_q;
        if (valid && !fault) begin
            state_d = hint ? btype_t'(0) : load_btype;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/bti_guard_checker.sv
module bti_guard_checker
    import bti_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_guarded,
    input  logic [BTYPE_W-1:0] in_btype,
    output logic              target_fault,
    output logic              pad_seen,
    output logic [FORM_W-1:0] pad_form,
    output logic [BTYPE_W-1:0] btype_state
);
    decode_t dec;
    logic    fault_now;
    btype_t  cur;

    bti_word_decoder u_dec (
        .word (in_word),
        .dec  (dec)
    );

    bti_fault_judge u_judge (
        .valid     (in_valid),
        .guarded   (in_guarded),
        .cur_btype (cur),
        .dec       (dec),
        .fault     (fault_now)
    );

    bti_btype_reg u_state (
        .clk        (clk),
        .rst        (rst),
        .valid      (in_valid),
        .fault      (fault_now),
        .hint       (dec.in_hint_space),
        .load_btype (in_btype),
        .state_q    (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            target_fault <= 1'b0;
            pad_seen     <= 1'b0;
            pad_form     <= '0;
        end else begin
            target_fault <= fault_now;
            pad_seen     <= in_valid && dec.is_pad;
            pad_form     <= (in_valid && dec.is_pad) ? dec.form : FORM_NONE;
        end
    end

    assign btype_state = cur;
endmodule

// File: rtl/bti_guard_checker_sva.sv
module bti_guard_checker_sva
    import bti_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_guarded,
    input logic [BTYPE_W-1:0] in_btype,
    input logic              target_fault,
    input logic              pad_seen,
    input logic [FORM_W-1:0] pad_form,
    input logic [BTYPE_W-1:0] btype_state
);
    // R2
    unguarded_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_guarded) |=> !target_fault);

    // R3
    zero_state_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && btype_state == 2'b00) |=> !target_fault);

    // R8
    fault_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        target_fault |-> (btype_state == $past(btype_state)) && (btype_state != 2'b00));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(btype_state) && !target_fault && !pad_seen);

    // R6
    pad_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_seen && !target_fault) |-> btype_state == 2'b00);

    // R1
    form_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pad_seen |-> pad_form == 2'b00);

    // R5
    fault_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        target_fault |-> $past(in_valid && in_guarded));
endmodule

bind bti_guard_checker bti_guard_checker_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_guarded   (in_guarded),
    .in_btype     (in_btype),
    .target_fault (target_fault),
    .pad_seen     (pad_seen),
    .pad_form     (pad_form),
    .btype_state  (btype_state)
);

// File: tb/bti_guard_checker_test.sv
`timescale 1ns/1ps
module bti_guard_checker_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_word;
    logic        in_guarded;
    logic [1:0]  in_btype;
    logic        target_fault;
    logic        pad_seen;
    logic [1:0]  pad_form;
    logic [1:0]  btype_state;

    int checks = 0;
    int fails  = 0;
    logic [1:0] m_state;

    always #4 clk = ~clk;

    bti_guard_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_guarded(in_guarded), .in_btype(in_btype),
        .target_fault(target_fault), .pad_seen(pad_seen),
        .pad_form(pad_form), .btype_state(btype_state)
    );

    localparam logic [31:0] PAD_BASE = 32'hD503241F;

    function automatic logic m_hint(input logic [31:0] w);
        return (w[31:12] == 20'b11010101000000110010) && (w[11:8] == 4'b0100)
            && (w[4:0] == 5'b11111);
    endfunction

    function automatic logic m_pad(input logic [31:0] w);
        return m_hint(w) && (w[5] == 1'b0);
    endfunction

    function automatic logic m_ok(input logic [1:0] f, input logic [1:0] bt);
        if (bt == 2'b00) return 1'b1;
        if (bt == 2'b01) return f != 2'b00;
        if (bt == 2'b10) return f == 2'b01 || f == 2'b11;
        return f == 2'b10 || f == 2'b11;
    endfunction

    function automatic logic [31:0] mk_hint(input logic [2:0] op2);
        return PAD_BASE | {24'd0, op2, 5'd0};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic g,
                        input logic [1:0] bt, input string req);
        logic e_fault, e_seen;
        logic [1:0] e_form, e_state;
        in_valid = v; in_word = w; in_guarded = g; in_btype = bt;
        e_seen  = v && m_pad(w);
        e_form  = e_seen ? w[7:6] : 2'b00;
        e_fault = v && g && (m_state != 2'b00) && !(m_pad(w) && m_ok(w[7:6], m_state));
        e_state = m_state;
        if (v && !e_fault) e_state = m_hint(w) ? 2'b00 : bt;
        @(posedge clk);
        @(negedge clk);
        m_state = e_state;
        check(req, "target_fault", {31'd0, target_fault}, {31'd0, e_fault});
        check(req, "pad_seen",     {31'd0, pad_seen},     {31'd0, e_seen});
        check(req, "pad_form",     {30'd0, pad_form},     {30'd0, e_form});
        check(req, "btype_state",  {30'd0, btype_state},  {30'd0, e_state});
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_state = 2'b00;
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_guarded = 1'b0; in_btype = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", "btype_state", {30'd0, btype_state}, 32'd0);
        check("R10", "target_fault", {31'd0, target_fault}, 32'd0);
        check("R10", "pad_seen", {31'd0, pad_seen}, 32'd0);
        rst = 1'b0;

        // R1 base pad decoded, R3 zero state
        step(1, PAD_BASE, 1, 2'b00, "R1");
        // R7 load nonzero type from ordinary word
        step(1, 32'h12345678, 0, 2'b10, "R7");
        // R9 idle holds
        step(0, PAD_BASE, 1, 2'b11, "R9");
        // R5 ordinary word faults, R8 holds state despite different in_btype
        step(1, 32'h8B020000, 1, 2'b01, "R5");
        step(1, 32'h8B020000, 1, 2'b11, "R8");
        // R4 full compatibility table; R6 clears
        for (int bt = 1; bt < 4; bt++) begin
            for (int f = 0; f < 4; f++) begin
                step(1, 32'h0, 0, 2'(bt), "R7");
                step(1, mk_hint(3'(f << 1)), 1, 2'b01, "R4");
            end
        end
        // R5 odd op2 hint faults in guarded nonzero state
        step(1, 32'h0, 0, 2'b11, "R7");
        step(1, mk_hint(3'b111), 1, 2'b10, "R5");
        // R6 odd op2 hint clears when it does not fault
        step(1, mk_hint(3'b011), 0, 2'b10, "R6");
        // R2 unguarded ordinary word with nonzero state
        step(1, 32'h0, 0, 2'b01, "R7");
        step(1, 32'hFFFFFFFF, 0, 2'b10, "R2");
        // R5 pulse drops after a passing word
        step(1, 32'h1, 1, 2'b00, "R5");
        step(1, mk_hint(3'b110), 1, 2'b00, "R5");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int sel = int'($urandom_range(0, 3));
            if (sel == 0)      w = mk_hint(3'($urandom_range(0, 7)));
            else if (sel == 1) w = PAD_BASE ^ (32'd1 << $urandom_range(0, 31));
            else               w = $urandom;
            step(1'($urandom_range(0, 4) != 0), w, 1'($urandom_range(0, 3) != 0),
                 2'($urandom_range(0, 3)), "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule